// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that software can read and write through a register port. The count advances on one of two event sources. The first is the core's instruction-cycle enable. The second is a chosen edge of an external pin, which passes through a two-flop synchronizer first. Between the event source and the counter sits a power-of-two prescaler, so that one count step can stand for 2 to 256 events. The prescaler can also be bypassed for a 1:1 ratio.

A 6-bit control register selects the source, the edge, the bypass and the ratio. The prescaler's internal count is never visible to software. It is cleared whenever software writes the count or the control register, and on every reset. When the count wraps from 0xFF to 0x00 it raises a sticky overflow flag, which stays set until software clears it. There are two reset inputs. An asynchronous active-low reset covers power-on and external reset. A synchronous active-high input carries the watchdog time-out reset, and it has exactly the same effect.

Top module: `tmr8_psc`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0 and the control register is 0x00 (internal source, rising edge, prescaler assigned at 1:2).
- R2: A count write (cnt_we high at a clock edge) loads cnt_wdata, and the new value is on cnt_q after that edge.
- R3: Control field layout: bit 5 selects the source (0 = tick_en, 1 = external pin); bit 4 selects the edge (0 = rising, 1 = falling); bit 3 = 1 bypasses the prescaler (1:1); bits 2..0 = n set the ratio to 1:2^(n+1). With the internal source and bypass, the count rises by one at each clock edge where tick_en is high.
- R4: With the prescaler assigned and ratio n, the count rises once for every 2^(n+1) events, counted from the last prescaler clear.
- R5: A count write clears the prescaler, so that a full 2^(n+1) events are needed after the write.
- R6: A control write clears the prescaler, even when it rewrites the same value.
- R7: With the external source and the rising edge, each low-to-high transition of ext_pin is one event. A pin change made before clock edge k shows on cnt_q after edge k+2. tick_en has no effect in this mode.
- R8: With the external source and bit 4 set, only high-to-low transitions of ext_pin count.
- R9: An increment from 0xFF wraps the count to 0x00 and sets ovf_flag. The flag stays set through further counting until ovf_clr is high at a clock edge.
- R10: When a count write and an increment fall in the same cycle, the written value is loaded exactly and the increment is lost.
- R11: wdt_rst high at a clock edge has the same effect as R1, including clearing the prescaler and the control register.
- R12: When an overflow and ovf_clr fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on/external reset |
| wdt_rst | input | 1 | Synchronous watchdog time-out reset, active high |
| tick_en | input | 1 | Instruction-cycle enable (internal event) |
| ext_pin | input | 1 | Asynchronous external event pin |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data (layout in R3) |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_q | output | 8 | Current count (read data) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The count is driven by bursts of tick_en events at ratios 1:1, 1:2, 1:8 and 1:256. Sampling just before and just after each multiple of the ratio separates a correct divider from one that is off by one event. Writes to the count and to the control register land part-way through a prescaler period, which shows whether the partial progress was discarded. Slow pin toggles in both edge modes, with tick_en pulses mixed in, separate edge polarity, source selection and the two-cycle synchronizer delay. Overflow is tried with a plain wrap, a clear on its own and a clear in the same cycle as a wrap, and both reset inputs are tried in the middle of activity.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int RATIO_W = 3;
    localparam int CTL_W   = 6;

    typedef struct packed {
        logic               src_ext;
        logic               fall_edge;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
    } ctl_t;

    localparam ctl_t CTL_RESET = '0;
endpackage

// File: rtl/tmr8_pin_sync.sv
module tmr8_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic pin_i,
    input  logic fall_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } st_t;

    st_t st_d, st_q;
    logic sync_lvl;

    assign sync_lvl = st_q.sh[STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_i};
        st_d.prev = sync_lvl;
        if (soft_rst_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = fall_i ? (st_q.prev & ~sync_lvl) : (sync_lvl & ~st_q.prev);
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int PSC_W = 2 ** RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst_i,
    input  logic               ev_i,
    input  logic               bypass_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               clr_i,
    output logic               inc_o
);
    typedef struct packed {
        logic [PSC_W-1:0] psc;
    } st_t;

    st_t st_d, st_q;
    logic [PSC_W-1:0] mask;
    logic             hit;

    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            mask[i] = (i <= int'(ratio_i));
        end
    end

    assign hit   = &(st_q.psc | ~mask);
    assign inc_o = bypass_i ? ev_i : (ev_i & hit);

    always_comb begin
        st_d = st_q;
        if (ev_i && !bypass_i) st_d.psc = st_q.psc + 1'b1;
        if (clr_i || soft_rst_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5 R6: any clear request leaves the prescaler at zero
    a_r6_psc_cleared: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        clr_i |=> (st_q.psc == '0));

    // R3: in bypass mode the prescaler holds its value
    a_r3_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (bypass_i && !clr_i) |=> $stable(st_q.psc));
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             inc_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } st_t;

    st_t  st_d, st_q;
    logic wrap;

    assign wrap = inc_i && !we_i && (st_q.cnt == CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (inc_i) st_d.cnt = st_q.cnt + 1'b1;
        if (we_i)  st_d.cnt = wdata_i;
        if (flag_clr_i) st_d.ovf = 1'b0;
        if (wrap)  st_d.ovf = 1'b1;
        if (soft_rst_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    // R2 R10: a write always lands exactly
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        we_i |=> (st_q.cnt == $past(wdata_i)));

    // R9 R12: wrapping from the top sets the flag
    a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (inc_i && !we_i && st_q.cnt == CNT_MAX) |=> (st_q.ovf && st_q.cnt == '0));

    // R9: the flag is sticky until cleared
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (st_q.ovf && !flag_clr_i) |=> st_q.ovf);

    // R3: without a write the count moves by at most one step
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        !we_i |=> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/tmr8_psc.sv
module tmr8_psc
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_rst,
    input  logic             tick_en,
    input  logic             ext_pin,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_flag
);
    ctl_t ctl_d, ctl_q;
    logic ext_edge;
    logic event_pulse;
    logic step;
    logic psc_clr;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we)  ctl_d = ctl_t'(ctl_wdata);
        if (wdt_rst) ctl_d = CTL_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    tmr8_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (wdt_rst),
        .pin_i      (ext_pin),
        .fall_i     (ctl_q.fall_edge),
        .edge_o     (ext_edge)
    );

    assign event_pulse = ctl_q.src_ext ? ext_edge : tick_en;
    assign psc_clr     = cnt_we | ctl_we;

    tmr8_prescaler u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (wdt_rst),
        .ev_i       (event_pulse),
        .bypass_i   (ctl_q.bypass),
        .ratio_i    (ctl_q.ratio),
        .clr_i      (psc_clr),
        .inc_o      (step)
    );

    tmr8_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (wdt_rst),
        .inc_i      (step),
        .we_i       (cnt_we),
        .wdata_i    (cnt_wdata),
        .flag_clr_i (ovf_clr),
        .cnt_o      (cnt_q),
        .ovf_o      (ovf_flag)
    );

    // R11: the watchdog reset returns count and flag to zero
    a_r11_wdt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (cnt_q == '0 && !ovf_flag));

    // R7: with the external source selected, tick_en alone never moves the count
    a_r7_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
        (ctl_q.src_ext && !ext_edge && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: tb/tmr8_psc_tb.sv
module tmr8_psc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_rst = 1'b0;
    logic       tick_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ovf_clr = 1'b0;
    logic [7:0] cnt_q;
    logic       ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    tmr8_psc u_dut (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .tick_en(tick_en),
        .ext_pin(ext_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
        .cnt_q(cnt_q), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk) begin cnt_we = 1'b1; cnt_wdata = v; end
        @(negedge clk) cnt_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        @(negedge clk) begin ctl_we = 1'b1; ctl_wdata = v; end
        @(negedge clk) ctl_we = 1'b0;
    endtask

    task automatic pin_set(input logic v);
        @(negedge clk) ext_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 count", cnt_q, 8'h00);
        check("R1 flag", ovf_flag, 0);
        ticks(1);
        check("R1 default 1:2 first", cnt_q, 8'h00);
        ticks(1);
        check("R1 default 1:2 second", cnt_q, 8'h01);
    endtask

    task automatic t_write();
        wr_cnt(8'h5A);
        check("R2 load", cnt_q, 8'h5A);
        wr_cnt(8'hC3);
        check("R2 reload", cnt_q, 8'hC3);
    endtask

    task automatic t_bypass();
        wr_ctl(6'h08);
        wr_cnt(8'h10);
        ticks(5);
        check("R3 bypass five", cnt_q, 8'h15);
        repeat (3) @(negedge clk);
        check("R3 idle holds", cnt_q, 8'h15);
    endtask

    task automatic t_ratio();
        wr_ctl(6'h02);
        wr_cnt(8'h00);
        ticks(7);
        check("R4 1:8 before", cnt_q, 8'h00);
        ticks(1);
        check("R4 1:8 at", cnt_q, 8'h01);
        ticks(16);
        check("R4 1:8 three", cnt_q, 8'h03);
        wr_ctl(6'h07);
        wr_cnt(8'h00);
        ticks(255);
        check("R4 1:256 before", cnt_q, 8'h00);
        ticks(1);
        check("R4 1:256 at", cnt_q, 8'h01);
    endtask

    task automatic t_clear_on_writes();
        wr_ctl(6'h02);
        wr_cnt(8'h00);
        ticks(5);
        wr_cnt(8'h10);
        ticks(7);
        check("R5 partial discarded", cnt_q, 8'h10);
        ticks(1);
        check("R5 full period", cnt_q, 8'h11);
        ticks(5);
        wr_ctl(6'h02);
        ticks(7);
        check("R6 partial discarded", cnt_q, 8'h11);
        ticks(1);
        check("R6 full period", cnt_q, 8'h12);
    endtask

    task automatic t_ext_rise();
        wr_ctl(6'h28);
        wr_cnt(8'h00);
        @(negedge clk) ext_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 sync delay", cnt_q, 8'h00);
        @(negedge clk);
        check("R7 first edge", cnt_q, 8'h01);
        pin_set(1'b0);
        check("R7 falling ignored", cnt_q, 8'h01);
        ticks(4);
        check("R7 tick ignored", cnt_q, 8'h01);
        for (int i = 0; i < 3; i++) begin
            pin_set(1'b1);
            pin_set(1'b0);
        end
        check("R7 four edges", cnt_q, 8'h04);
    endtask

    task automatic t_ext_fall();
        wr_ctl(6'h38);
        wr_cnt(8'h00);
        pin_set(1'b1);
        check("R8 rising ignored", cnt_q, 8'h00);
        pin_set(1'b0);
        check("R8 falling counted", cnt_q, 8'h01);
        pin_set(1'b1);
        pin_set(1'b0);
        check("R8 second fall", cnt_q, 8'h02);
    endtask

    task automatic t_overflow();
        wr_ctl(6'h08);
        wr_cnt(8'hFE);
        ticks(1);
        check("R9 at top", cnt_q, 8'hFF);
        check("R9 flag low", ovf_flag, 0);
        ticks(1);
        check("R9 wrap", cnt_q, 8'h00);
        check("R9 flag set", ovf_flag, 1);
        ticks(3);
        check("R9 flag sticky", ovf_flag, 1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        check("R9 flag cleared", ovf_flag, 0);
        wr_cnt(8'hFF);
        @(negedge clk) begin tick_en = 1'b1; ovf_clr = 1'b1; end
        @(negedge clk) begin tick_en = 1'b0; ovf_clr = 1'b0; end
        check("R12 set beats clear", ovf_flag, 1);
        check("R12 wrapped", cnt_q, 8'h00);
    endtask

    task automatic t_priority();
        wr_ctl(6'h08);
        wr_cnt(8'h20);
        @(negedge clk) begin cnt_we = 1'b1; cnt_wdata = 8'h40; tick_en = 1'b1; end
        @(negedge clk) begin cnt_we = 1'b0; tick_en = 1'b0; end
        check("R10 write wins", cnt_q, 8'h40);
        wr_cnt(8'hFF);
        @(negedge clk) begin ovf_clr = 1'b1; end
        @(negedge clk) begin ovf_clr = 1'b0; cnt_we = 1'b1; cnt_wdata = 8'h07; tick_en = 1'b1; end
        @(negedge clk) begin cnt_we = 1'b0; tick_en = 1'b0; end
        check("R10 write over wrap", cnt_q, 8'h07);
        check("R10 no flag", ovf_flag, 0);
    endtask

    task automatic t_wdt();
        wr_ctl(6'h00);
        wr_cnt(8'h33);
        ticks(1);
        @(negedge clk) wdt_rst = 1'b1;
        @(negedge clk) wdt_rst = 1'b0;
        check("R11 count", cnt_q, 8'h00);
        ticks(1);
        check("R11 prescaler cleared", cnt_q, 8'h00);
        ticks(1);
        check("R11 after two", cnt_q, 8'h01);
        wr_ctl(6'h28);
        wr_cnt(8'h00);
        @(negedge clk) wdt_rst = 1'b1;
        @(negedge clk) wdt_rst = 1'b0;
        ticks(2);
        check("R11 control reset", cnt_q, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_bypass();
        t_ratio();
        t_clear_on_writes();
        t_ext_rise();
        t_ext_fall();
        t_overflow();
        t_priority();
        t_wdt();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule